// File: doc/BRIEF.md
# Immediate Field Logic Execution Unit

This execute-stage block applies a bitwise operation with an immediate operand to one field of a 64-bit general register. The operation is AND, OR, XOR or INSERT. The register comes from a 16-entry external register file. The unit decodes a 32-bit short instruction or a 48-bit long instruction. It reads the addressed register through a combinational read port, places the immediate onto the selected 16-bit or 32-bit field, and computes the new value. On the next rising clock edge it presents that value on a registered write port.

The logical operations also update a 2-bit condition code. That code looks only at the selected field of the result. INSERT leaves the condition code as it was. An instruction whose primary opcode or sub-op is not recognised raises a one-cycle illegal flag and writes nothing.

A write that is still pending on the write port is forwarded to the next instruction's read. Instructions can therefore issue on every cycle, even when they name the same register.

Top module: `imm_field_exu`

## Requirements
- R1: Short form (`long_i`=0): bits 31:24 equal 0xA5, bits 23:20 give the register, bits 19:16 the sub-op and bits 15:0 the unsigned immediate. Sub-ops 0–3 are INSERT, 4–7 are AND and 8–11 are OR. Within each group, the sub-op's two low bits select the 16-bit field at bit 48, 32, 16 or 0, in that order.
- R2: Long form (`long_i`=1): bits 47:40 equal 0xC0, bits 39:36 give the register, bits 35:32 the sub-op and bits 31:0 the unsigned immediate. Sub-ops 6/7 are XOR, 8/9 INSERT, 10/11 AND and 12/13 OR. An even sub-op targets bits 63:32 and an odd sub-op targets bits 31:0.
- R3: AND replaces the field with the old field ANDed with the immediate. Every bit outside the field keeps its old value.
- R4: OR and XOR combine the field with the immediate. Every bit outside the field keeps its old value.
- R5: INSERT puts the immediate into the field, keeps all other bits and leaves `cc_o` unchanged.
- R6: After AND, OR or XOR, `cc_o` is 0 when the field of the result is all zeros and 1 otherwise. Bits outside the field have no effect on it.
- R7: A wrong primary opcode or an unlisted sub-op sets `illegal_o` for one cycle. It leaves `rf_we_o` low and `cc_o` unchanged.
- R8: A valid instruction sampled on a rising edge shows its result on `rf_we_o`, `rf_waddr_o`, `rf_wdata_o` and `cc_o` after that same edge. With `valid_i` low, the next cycle has no write and no illegal flag, and `cc_o` holds.
- R9: When an instruction reads the register that the previous instruction is still writing, it operates on the forwarded new value.
- R10: During reset, `rf_we_o`, `illegal_o` and `cc_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| long_i | input | 1 | 1: 48-bit long form, 0: 32-bit short form in bits 31:0 |
| insn_i | input | 48 | Instruction word |
| rf_raddr_o | output | 4 | Register file read address |
| rf_rdata_i | input | 64 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write address |
| rf_wdata_o | output | 64 | Register file write data |
| cc_o | output | 2 | Condition code: 0 means field zero, 1 means field nonzero |
| illegal_o | output | 1 | Illegal instruction seen |

## Verification
Two things can fall in the same cycle: the write-back of one instruction and the register read of the next. The bench provokes this by issuing instructions with no idle cycles between them, including chains of operations on a single register. It judges the result against a bit-by-bit reference model, both on the write port and in the bench's own register file. A second overlap is a condition-code update followed at once by an INSERT or an illegal instruction. The bench checks that `cc_o` keeps the value from the earlier logical operation.

// File: rtl/imm_exu_pkg.sv
package imm_exu_pkg;
  localparam int XLEN     = 64;
  localparam int LANE_W   = 16;
  localparam int NLANE    = XLEN / LANE_W;
  localparam int LSEL_W   = $clog2(NLANE);
  localparam int NREG     = 16;
  localparam int RAW      = $clog2(NREG);
  localparam int IMM_W    = 2 * LANE_W;
  localparam int ILEN     = 48;
  localparam int CC_W     = 2;
  localparam logic [7:0] SHORT_PRI = 8'hA5;
  localparam logic [7:0] LONG_PRI  = 8'hC0;

  typedef enum logic [1:0] {OP_INS, OP_AND, OP_OR, OP_XOR} fop_e;

  typedef struct packed {
    logic              legal;
    fop_e              op;
    logic [RAW-1:0]    rnum;
    logic [LSEL_W-1:0] lane_lo;  // lowest 16-bit lane of the field
    logic              wide;     // 32-bit field
    logic [IMM_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/imm_exu_decode.sv
module imm_exu_decode
  import imm_exu_pkg::*;
(
  input  logic [ILEN-1:0] insn_i,
  input  logic            long_i,
  output dec_t            dec_o
);
  logic [3:0] sub;

  always_comb begin
    dec_o = '0;
    sub   = '0;
    if (!long_i) begin
      sub           = insn_i[19:16];
      dec_o.rnum    = insn_i[23:20];
      dec_o.imm     = {{(IMM_W-LANE_W){1'b0}}, insn_i[15:0]};
      dec_o.wide    = 1'b0;
      // sub-op low bits count fields from the top down
      dec_o.lane_lo = LSEL_W'(NLANE - 1) - sub[1:0];
      dec_o.legal   = (insn_i[31:24] == SHORT_PRI);
      unique case (sub[3:2])
        2'd0:    dec_o.op = OP_INS;
        2'd1:    dec_o.op = OP_AND;
        2'd2:    dec_o.op = OP_OR;
        default: dec_o.legal = 1'b0;
      endcase
    end else begin
      sub           = insn_i[35:32];
      dec_o.rnum    = insn_i[39:36];
      dec_o.imm     = insn_i[31:0];
      dec_o.wide    = 1'b1;
      dec_o.lane_lo = sub[0] ? LSEL_W'(0) : LSEL_W'(NLANE / 2);
      dec_o.legal   = (insn_i[47:40] == LONG_PRI);
      unique case (sub)
        4'h6, 4'h7: dec_o.op = OP_XOR;
        4'h8, 4'h9: dec_o.op = OP_INS;
        4'hA, 4'hB: dec_o.op = OP_AND;
        4'hC, 4'hD: dec_o.op = OP_OR;
        default:    dec_o.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/imm_exu_align.sv
module imm_exu_align
  import imm_exu_pkg::*;
(
  input  logic [LSEL_W-1:0] lane_lo_i,
  input  logic              wide_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [XLEN-1:0]   imm_sh_o,
  output logic [XLEN-1:0]   fmask_o
);
  logic [LSEL_W:0] lane_hi;
  assign lane_hi = {1'b0, lane_lo_i} + 1'b1;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic sel_lo, sel_hi;
    assign sel_lo = (LSEL_W'(l) == lane_lo_i);
    assign sel_hi = wide_i && ((LSEL_W+1)'(l) == lane_hi);
    assign fmask_o[l*LANE_W +: LANE_W]  = {LANE_W{sel_lo | sel_hi}};
    assign imm_sh_o[l*LANE_W +: LANE_W] = sel_lo ? imm_i[0 +: LANE_W]
                                        : sel_hi ? imm_i[LANE_W +: LANE_W]
                                        : '0;
  end
endmodule

// File: rtl/imm_exu_alu.sv
module imm_exu_alu
  import imm_exu_pkg::*;
(
  input  fop_e            op_i,
  input  logic [XLEN-1:0] opnd_i,
  input  logic [XLEN-1:0] imm_sh_i,
  input  logic [XLEN-1:0] fmask_i,
  output logic [XLEN-1:0] res_o,
  output logic            field_nz_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = opnd_i & (imm_sh_i | ~fmask_i);
      OP_OR:   res_o = opnd_i | imm_sh_i;
      OP_XOR:  res_o = opnd_i ^ imm_sh_i;
      default: res_o = (opnd_i & ~fmask_i) | imm_sh_i;
    endcase
  end

  assign field_nz_o = |(res_o & fmask_i);
endmodule

// File: rtl/imm_field_exu.sv
module imm_field_exu
  import imm_exu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            long_i,
  input  logic [47:0]     insn_i,
  output logic [3:0]      rf_raddr_o,
  input  logic [63:0]     rf_rdata_i,
  output logic            rf_we_o,
  output logic [3:0]      rf_waddr_o,
  output logic [63:0]     rf_wdata_o,
  output logic [1:0]      cc_o,
  output logic            illegal_o
);
  dec_t            dec;
  logic [XLEN-1:0] opnd, imm_sh, fmask, alu_res;
  logic            field_nz, fwd;

  imm_exu_decode u_dec (
    .insn_i (insn_i),
    .long_i (long_i),
    .dec_o  (dec)
  );

  assign rf_raddr_o = dec.rnum;
  // pending write not yet in the file: bypass it
  assign fwd  = rf_we_o && (rf_waddr_o == dec.rnum);
  assign opnd = fwd ? rf_wdata_o : rf_rdata_i;

  imm_exu_align u_align (
    .lane_lo_i (dec.lane_lo),
    .wide_i    (dec.wide),
    .imm_i     (dec.imm),
    .imm_sh_o  (imm_sh),
    .fmask_o   (fmask)
  );

  imm_exu_alu u_alu (
    .op_i       (dec.op),
    .opnd_i     (opnd),
    .imm_sh_i   (imm_sh),
    .fmask_i    (fmask),
    .res_o      (alu_res),
    .field_nz_o (field_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_we_o    <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      cc_o       <= '0;
      illegal_o  <= 1'b0;
    end else begin
      rf_we_o   <= valid_i && dec.legal;
      illegal_o <= valid_i && !dec.legal;
      if (valid_i && dec.legal) begin
        rf_waddr_o <= dec.rnum;
        rf_wdata_o <= alu_res;
        if (dec.op != OP_INS) cc_o <= {1'b0, field_nz};
      end
    end
  end

  // R7
  illegal_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !dec.legal |=> illegal_o && !rf_we_o && $stable(cc_o));

  // R5
  insert_keeps_cc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.legal && dec.op == OP_INS |=> $stable(cc_o));

  // R8
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !rf_we_o && !illegal_o && $stable(cc_o));

  // R3 R4
  outside_field_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.legal |-> ((alu_res ^ opnd) & ~fmask) == '0);

  // R6
  cc_from_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.legal && dec.op != OP_INS |=>
      cc_o == (((rf_wdata_o & $past(fmask)) != '0) ? 2'd1 : 2'd0));

  // R8
  write_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.legal |=> rf_we_o && rf_waddr_o == $past(rf_raddr_o));
endmodule

// File: tb/tb_imm_field_exu.sv
`timescale 1ns/1ps
module tb_imm_field_exu;
  logic        clk = 1'b0;
  logic        rst_ni, valid_i, long_i;
  logic [47:0] insn_i;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [63:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, illegal_o;
  logic [1:0]  cc_o;

  logic [63:0] rf  [16];
  logic [63:0] mdl [16];
  logic [1:0]  exp_cc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  imm_field_exu dut (.*, .clk_i(clk));

  assign rf_rdata_i = rf[rf_raddr_o];
  always @(posedge clk) if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] sw(input logic [3:0] sub, input logic [3:0] r, input logic [15:0] imm);
    return {16'h0, 8'hA5, r, sub, imm};
  endfunction

  function automatic logic [47:0] lw(input logic [3:0] sub, input logic [3:0] r, input logic [31:0] imm);
    return {8'hC0, r, sub, imm};
  endfunction

  // reference: kind 0 insert, 1 and, 2 or, 3 xor
  task automatic ref_exec(input logic [47:0] w, input bit lng, output bit legal,
                          output int r, output logic [63:0] nv, output bit upd, output bit nz);
    int kind, lsb, wd, s;
    logic [31:0] imm;
    kind = 0; legal = 0;
    if (!lng) begin
      s = int'(w[19:16]); r = int'(w[23:20]); imm = {16'h0, w[15:0]};
      legal = (w[31:24] == 8'hA5) && s < 12;
      kind = s / 4; lsb = 48 - 16 * (s % 4); wd = 16;
    end else begin
      s = int'(w[35:32]); r = int'(w[39:36]); imm = w[31:0];
      legal = (w[47:40] == 8'hC0) && s >= 6 && s <= 13;
      if (s == 6 || s == 7) kind = 3;
      else if (s == 8 || s == 9) kind = 0;
      else if (s == 10 || s == 11) kind = 1;
      else kind = 2;
      lsb = (s % 2 == 1) ? 0 : 32; wd = 32;
    end
    nv = mdl[r]; nz = 0;
    for (int i = 0; i < wd; i++) begin
      case (kind)
        0: nv[lsb+i] = imm[i];
        1: nv[lsb+i] = mdl[r][lsb+i] & imm[i];
        2: nv[lsb+i] = mdl[r][lsb+i] | imm[i];
        default: nv[lsb+i] = mdl[r][lsb+i] ^ imm[i];
      endcase
      nz |= nv[lsb+i];
    end
    upd = legal && kind != 0;
  endtask

  // called at a negedge; returns at the following negedge with valid_i low
  task automatic exec(input logic [47:0] w, input bit lng, input string tag);
    bit legal, upd, nz; int r; logic [63:0] nv;
    ref_exec(w, lng, legal, r, nv, upd, nz);
    valid_i = 1'b1; long_i = lng; insn_i = w;
    @(negedge clk);
    check(rf_we_o == legal, {tag, " we"}, 64'(rf_we_o), 64'(legal));
    check(illegal_o == !legal, {tag, " illegal R7"}, 64'(illegal_o), 64'(!legal));
    if (legal) begin
      check(rf_waddr_o == 4'(r), {tag, " waddr"}, 64'(rf_waddr_o), 64'(r));
      check(rf_wdata_o == nv, {tag, " wdata"}, rf_wdata_o, nv);
      mdl[r] = nv;
    end
    if (upd) exp_cc = nz ? 2'd1 : 2'd0;
    check(cc_o == exp_cc, {tag, " cc"}, 64'(cc_o), 64'(exp_cc));
    valid_i = 1'b0;
  endtask

  task automatic chk_rf(input int r, input string tag);
    @(negedge clk);
    check(rf[r] === mdl[r], {tag, " regfile"}, rf[r], mdl[r]);
  endtask

  task automatic load(input int r, input logic [63:0] v);
    for (int k = 0; k < 4; k++)
      exec(sw(4'(k), 4'(r), v[63-16*k -: 16]), 0, "R1 R5 load insert");
  endtask

  task automatic t_reset;
    check(rf_we_o == 0, "R10 we", 64'(rf_we_o), 0);
    check(illegal_o == 0, "R10 illegal", 64'(illegal_o), 0);
    check(cc_o == 0, "R10 cc", 64'(cc_o), 0);
  endtask

  task automatic t_short;
    load(1, 64'h1234_5678_9ABC_DEF0);
    chk_rf(1, "R1 R9 load");
    exec(sw(4'h4, 4'd1, 16'h0F0F), 0, "R3 AND hh");
    exec(sw(4'h7, 4'd1, 16'h0000), 0, "R3 R6 AND ll zero");
    exec(sw(4'h9, 4'd1, 16'h8001), 0, "R4 OR hl");
    exec(sw(4'hA, 4'd1, 16'h0000), 0, "R4 R6 OR lh");
    exec(sw(4'h1, 4'd1, 16'hCAFE), 0, "R5 INS hl");
    chk_rf(1, "R9 short chain");
  endtask

  task automatic t_long;
    load(2, 64'hFFFF_0000_AAAA_5555);
    exec(lw(4'h6, 4'd2, 32'hFFFF_FFFF), 1, "R2 R4 XOR hi");
    exec(lw(4'h7, 4'd2, 32'hAAAA_5555), 1, "R2 R6 XOR lo zero");
    exec(lw(4'hA, 4'd2, 32'h00FF_FF00), 1, "R2 R3 AND hi");
    exec(lw(4'hB, 4'd2, 32'h1234_5678), 1, "R2 R3 AND lo");
    exec(lw(4'hC, 4'd2, 32'h8000_0000), 1, "R2 R4 OR hi");
    exec(lw(4'hD, 4'd2, 32'h0000_0001), 1, "R2 R4 OR lo");
    exec(lw(4'h8, 4'd2, 32'hDEAD_BEEF), 1, "R2 R5 INS hi");
    exec(lw(4'h9, 4'd2, 32'h0000_0000), 1, "R2 R5 INS lo");
    chk_rf(2, "R2 long chain");
  endtask

  task automatic t_cc_outside;
    // R6: field zero while the rest is all ones
    load(3, 64'hFFFF_FFFF_FFFF_0001);
    exec(sw(4'h7, 4'd3, 16'hFFFE), 0, "R6 field zero outside ones");
    exec(lw(4'hD, 4'd3, 32'h0), 1, "R6 OR lo zero imm");
    exec(sw(4'h8, 4'd3, 16'h0), 0, "R6 OR hh nonzero field");
    exec(sw(4'h3, 4'd3, 16'h0), 0, "R5 INS keeps cc");
  endtask

  task automatic t_illegal;
    exec(sw(4'hC, 4'd1, 16'hFFFF), 0, "R7 short sub 12");
    exec(sw(4'hF, 4'd1, 16'hFFFF), 0, "R7 short sub 15");
    exec({16'h0, 8'hA6, 4'd1, 4'h4, 16'h0}, 0, "R7 short bad primary");
    exec(lw(4'h5, 4'd2, 32'h0), 1, "R7 long sub 5");
    exec(lw(4'hE, 4'd2, 32'h0), 1, "R7 long sub 14");
    exec({8'hC1, 4'd2, 4'hA, 32'h0}, 1, "R7 long bad primary");
    chk_rf(1, "R7 r1 untouched");
    chk_rf(2, "R7 r2 untouched");
  endtask

  task automatic t_idle;
    @(negedge clk);
    check(rf_we_o == 0, "R8 idle we", 64'(rf_we_o), 0);
    check(illegal_o == 0, "R8 idle illegal", 64'(illegal_o), 0);
    check(cc_o == exp_cc, "R8 idle cc", 64'(cc_o), 64'(exp_cc));
  endtask

  task automatic t_b2b;
    load(4, 64'h0);
    load(5, 64'hFFFF_FFFF_FFFF_FFFF);
    exec(sw(4'hB, 4'd4, 16'h00F0), 0, "R9 b2b OR");
    exec(sw(4'hB, 4'd4, 16'h0F00), 0, "R9 b2b OR again");
    exec(sw(4'h7, 4'd4, 16'h0FF0), 0, "R9 b2b AND");
    exec(sw(4'h7, 4'd5, 16'h0000), 0, "R9 other reg");
    exec(lw(4'h7, 4'd4, 32'hFFFF_FFFF), 1, "R9 b2b XOR");
    chk_rf(4, "R9 b2b r4");
    chk_rf(5, "R9 b2b r5");
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; long_i = 1'b0; insn_i = '0; exp_cc = 2'd0;
    for (int i = 0; i < 16; i++) begin rf[i] = '0; mdl[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_short();
    t_long();
    t_cc_outside();
    t_illegal();
    t_idle();
    t_b2b();
    t_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 act=%h exp=%h", 64'(0), 64'(1));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule